// File: doc/BRIEF.md
# Drift-Event Leaky Bucket Activity Monitor

This block decides whether one input clock is fit for selection by counting how often it drifts out of tolerance. An external comparator judges each 128 ms observation window and hands the block a one-cycle window-end pulse plus a flag that says whether the clock strayed beyond ±500 ppm of the system clock during that window. The block keeps a saturating fill counter that rises by one on each window with a drift event. It falls by one after a programmable run of clean windows.

Four configuration profiles are presented at the inputs. A 2-bit select picks the active one. Each profile carries a capacity, a raise threshold, a clear threshold and a 2-bit decay code. The alarm is raised when the fill climbs past the raise threshold. It drops only once the fill has sunk below the clear threshold, so the block has hysteresis. The qualified output is the inverse of the alarm and feeds clock selection. The fill level is also brought out so that the level driving the alarm can be observed.

Top module: `drift_bucket_mon`

## Requirements
- R1: After reset the fill is 0, the alarm is low and qualified is high.
- R2: A window end with the drift flag set raises the fill by exactly 1. The drift flag has no effect on the fill when the window-end pulse is low.
- R3: The fill never rises above the capacity of the active profile. A drift window at or above the capacity leaves the fill unchanged.
- R4: With decay code d (0..3), the fill drops by 1 on the 2^d-th consecutive clean window (1, 2, 4 or 8 windows), and the run count then starts again.
- R5: A drift window restarts the count of consecutive clean windows from zero.
- R6: The fill never goes below 0. A clean window at fill 0 leaves it at 0.
- R7: The alarm goes high on the edge where the fill becomes strictly greater than the raise threshold. A fill equal to the raise threshold does not raise the alarm.
- R8: Once high, the alarm stays high while the fill is at or above the clear threshold. It goes low on the edge where the fill becomes strictly less than the clear threshold.
- R9: qualified_o is always the inverse of alarm_o.
- R10: prof_sel_i = k selects element k of each profile input vector (bits [8k+7:8k] of the 8-bit fields, bits [2k+1:2k] of the decay codes). The selected profile applies from the next window on, and the fill is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_end_i | input | 1 | One-cycle pulse at the end of each observation window |
| drift_evt_i | input | 1 | Drift event seen in the window that is ending |
| prof_sel_i | input | 2 | Active profile index |
| prof_size_i | input | 4x8 | Capacity per profile |
| prof_upper_i | input | 4x8 | Raise threshold per profile |
| prof_lower_i | input | 4x8 | Clear threshold per profile |
| prof_decay_i | input | 4x2 | Decay code per profile |
| fill_o | output | 8 | Current fill level |
| alarm_o | output | 1 | No-activity alarm |
| qualified_o | output | 1 | Clock usable for selection |

## Verification
The fill, the alarm and the qualified flag all change on the same rising edge that samples the window-end pulse, so each window result is due one edge after its stimulus. The bench drives every input on the falling edge. It reads the outputs on the next falling edge, half a cycle after the update and well before the following one. A threshold or profile change that occurs between windows takes effect on the alarm at the very next edge, because the alarm is re-evaluated every cycle. The bench therefore changes profiles only while no window is pending and checks only after a window has been applied.

// File: rtl/drift_bucket_pkg.sv
package drift_bucket_pkg;
  parameter int N_PROF = 4;
  parameter int CNT_W  = 8;
  parameter int DEC_W  = 2;
  localparam int SEL_W  = $clog2(N_PROF);
  // longest decay run is 2^(2^DEC_W - 1) windows
  localparam int IDLE_W = (1 << DEC_W);

  typedef struct packed {
    logic [CNT_W-1:0] size;
    logic [CNT_W-1:0] upper;
    logic [CNT_W-1:0] lower;
    logic [DEC_W-1:0] decay;
  } prof_t;
endpackage

// File: rtl/drift_bucket_cfg_sel.sv
module drift_bucket_cfg_sel
  import drift_bucket_pkg::*;
(
  input  logic [SEL_W-1:0]             sel_i,
  input  logic [N_PROF-1:0][CNT_W-1:0] size_i,
  input  logic [N_PROF-1:0][CNT_W-1:0] upper_i,
  input  logic [N_PROF-1:0][CNT_W-1:0] lower_i,
  input  logic [N_PROF-1:0][DEC_W-1:0] decay_i,
  output prof_t                        prof_o
);
  prof_t tbl [N_PROF];

  for (genvar k = 0; k < N_PROF; k++) begin : g_prof
    assign tbl[k].size  = size_i[k];
    assign tbl[k].upper = upper_i[k];
    assign tbl[k].lower = lower_i[k];
    assign tbl[k].decay = decay_i[k];
  end

  always_comb begin
    prof_o = tbl[0];
    for (int k = 0; k < N_PROF; k++) begin
      if (sel_i == SEL_W'(k)) prof_o = tbl[k];
    end
  end
endmodule

// File: rtl/drift_bucket_decay.sv
module drift_bucket_decay
  import drift_bucket_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_end_i,
  input  logic             drift_evt_i,
  input  logic [DEC_W-1:0] decay_i,
  output logic             dec_o
);
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic [IDLE_W-1:0] last_idx;
  logic              clean_win;

  assign last_idx  = IDLE_W'((IDLE_W'(1) << decay_i) - IDLE_W'(1));
  assign clean_win = win_end_i & ~drift_evt_i;
  // >= covers a decay code lowered mid-run
  assign dec_o     = clean_win & (idle_q >= last_idx);

  always_comb begin
    idle_d = idle_q;
    if (win_end_i) begin
      if (drift_evt_i || dec_o) idle_d = '0;
      else                      idle_d = idle_q + IDLE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_q <= '0;
    else         idle_q <= idle_d;
  end
endmodule

// File: rtl/drift_bucket_acc.sv
module drift_bucket_acc
  import drift_bucket_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] size_i,
  output logic [CNT_W-1:0] fill_d_o,
  output logic [CNT_W-1:0] fill_q_o
);
  logic [CNT_W-1:0] fill_q, fill_d;

  always_comb begin
    fill_d = fill_q;
    if (inc_i) begin
      if (fill_q < size_i) fill_d = fill_q + CNT_W'(1);
    end else if (dec_i) begin
      if (fill_q != '0) fill_d = fill_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else         fill_q <= fill_d;
  end

  assign fill_d_o = fill_d;
  assign fill_q_o = fill_q;
endmodule

// File: rtl/drift_bucket_hyst.sv
module drift_bucket_hyst
  import drift_bucket_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] fill_i,
  input  logic [CNT_W-1:0] upper_i,
  input  logic [CNT_W-1:0] lower_i,
  output logic             alarm_o
);
  logic alarm_q, alarm_d;

  always_comb begin
    alarm_d = alarm_q;
    if (fill_i > upper_i)      alarm_d = 1'b1;
    else if (fill_i < lower_i) alarm_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alarm_q <= 1'b0;
    else         alarm_q <= alarm_d;
  end

  assign alarm_o = alarm_q;
endmodule

// File: rtl/drift_bucket_mon.sv
module drift_bucket_mon
  import drift_bucket_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         win_end_i,
  input  logic                         drift_evt_i,
  input  logic [SEL_W-1:0]             prof_sel_i,
  input  logic [N_PROF-1:0][CNT_W-1:0] prof_size_i,
  input  logic [N_PROF-1:0][CNT_W-1:0] prof_upper_i,
  input  logic [N_PROF-1:0][CNT_W-1:0] prof_lower_i,
  input  logic [N_PROF-1:0][DEC_W-1:0] prof_decay_i,
  output logic [CNT_W-1:0]             fill_o,
  output logic                         alarm_o,
  output logic                         qualified_o
);
  prof_t            prof;
  logic             dec;
  logic [CNT_W-1:0] fill_d;

  drift_bucket_cfg_sel u_cfg_sel (
    .sel_i   (prof_sel_i),
    .size_i  (prof_size_i),
    .upper_i (prof_upper_i),
    .lower_i (prof_lower_i),
    .decay_i (prof_decay_i),
    .prof_o  (prof)
  );

  drift_bucket_decay u_decay (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_end_i   (win_end_i),
    .drift_evt_i (drift_evt_i),
    .decay_i     (prof.decay),
    .dec_o       (dec)
  );

  drift_bucket_acc u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (win_end_i & drift_evt_i),
    .dec_i    (dec),
    .size_i   (prof.size),
    .fill_d_o (fill_d),
    .fill_q_o (fill_o)
  );

  // judged on the value the fill takes at this edge
  drift_bucket_hyst u_hyst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fill_i  (fill_d),
    .upper_i (prof.upper),
    .lower_i (prof.lower),
    .alarm_o (alarm_o)
  );

  assign qualified_o = ~alarm_o;
endmodule

// File: rtl/drift_bucket_mon_chk.sv
module drift_bucket_mon_chk
  import drift_bucket_pkg::*;
(
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         win_end_i,
  input logic                         drift_evt_i,
  input logic [SEL_W-1:0]             prof_sel_i,
  input logic [N_PROF-1:0][CNT_W-1:0] prof_size_i,
  input logic [N_PROF-1:0][CNT_W-1:0] prof_upper_i,
  input logic [N_PROF-1:0][CNT_W-1:0] prof_lower_i,
  input logic [N_PROF-1:0][DEC_W-1:0] prof_decay_i,
  input logic [CNT_W-1:0]             fill_o,
  input logic                         alarm_o,
  input logic                         qualified_o
);
  logic [CNT_W-1:0] sel_size, sel_upper, sel_lower;
  assign sel_size  = prof_size_i[prof_sel_i];
  assign sel_upper = prof_upper_i[prof_sel_i];
  assign sel_lower = prof_lower_i[prof_sel_i];

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end_i && drift_evt_i && fill_o < sel_size) |=> fill_o == $past(fill_o) + CNT_W'(1));

  a_r2_no_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end_i |=> $stable(fill_o));

  a_r3_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end_i && drift_evt_i && fill_o >= sel_size) |=> $stable(fill_o));

  a_r6_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end_i && !drift_evt_i && fill_o == '0) |=> fill_o == '0);

  a_r7_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_o > $past(sel_upper)) |-> alarm_o);

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_o < $past(sel_lower) && fill_o <= $past(sel_upper)) |-> !alarm_o);

  a_r9_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> !qualified_o);
endmodule

bind drift_bucket_mon drift_bucket_mon_chk u_chk (.*);

// File: tb/drift_bucket_mon_bench.sv
module drift_bucket_mon_bench;
  import drift_bucket_pkg::*;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic win_end_i = 1'b0;
  logic drift_evt_i = 1'b0;
  logic [SEL_W-1:0] prof_sel_i = '0;
  logic [N_PROF-1:0][CNT_W-1:0] prof_size_i, prof_upper_i, prof_lower_i;
  logic [N_PROF-1:0][DEC_W-1:0] prof_decay_i;
  logic [CNT_W-1:0] fill_o;
  logic alarm_o, qualified_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  drift_bucket_mon u_drift_bucket_mon (.*);

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    win_end_i = 1'b0; drift_evt_i = 1'b0; rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // one window: pulse at a falling edge, result read at the next
  task automatic window(bit evt);
    win_end_i = 1'b1; drift_evt_i = evt;
    @(negedge clk_i);
    win_end_i = 1'b0; drift_evt_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic windows(bit evt, int n);
    for (int i = 0; i < n; i++) window(evt);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 fill", fill_o, 0);
    check("R1 alarm", alarm_o, 0);
    check("R1 qualified", qualified_o, 1);
  endtask

  task automatic t_ignore();
    do_reset();
    prof_sel_i = 2'd0;
    drift_evt_i = 1'b1;
    repeat (5) @(negedge clk_i);
    drift_evt_i = 1'b0;
    @(negedge clk_i);
    check("R2 flag without window", fill_o, 0);
  endtask

  // profile 0: size 10, upper 5, lower 2, decay code 0
  task automatic t_hysteresis();
    do_reset();
    prof_sel_i = 2'd0;
    windows(1'b1, 3);
    check("R2 three events", fill_o, 3);
    windows(1'b1, 2);
    check("R7 fill at upper", fill_o, 5);
    check("R7 no alarm at equal", alarm_o, 0);
    window(1'b1);
    check("R7 alarm above upper", alarm_o, 1);
    check("R9 not qualified", qualified_o, 0);
    windows(1'b1, 6);
    check("R3 saturate at size", fill_o, 10);
    windows(1'b0, 3);
    check("R4 decay code 0", fill_o, 7);
    windows(1'b0, 5);
    check("R8 fill at lower", fill_o, 2);
    check("R8 alarm held at lower", alarm_o, 1);
    window(1'b0);
    check("R8 alarm cleared", alarm_o, 0);
    check("R9 qualified again", qualified_o, 1);
    windows(1'b0, 3);
    check("R6 floor at zero", fill_o, 0);
  endtask

  // profile 1: decay code 2 -> four clean windows per step
  task automatic t_decay4();
    do_reset();
    prof_sel_i = 2'd1;
    windows(1'b1, 5);
    windows(1'b0, 3);
    check("R4 three clean of four", fill_o, 5);
    window(1'b0);
    check("R4 fourth clean", fill_o, 4);
    windows(1'b0, 2);
    window(1'b1);
    check("R2 event mid run", fill_o, 5);
    windows(1'b0, 3);
    check("R5 run restarted", fill_o, 5);
    window(1'b0);
    check("R5 step after full run", fill_o, 4);
  endtask

  // profile 3: decay code 3 -> eight clean windows per step
  task automatic t_decay8();
    do_reset();
    prof_sel_i = 2'd3;
    windows(1'b1, 2);
    windows(1'b0, 7);
    check("R4 seven clean of eight", fill_o, 2);
    window(1'b0);
    check("R4 eighth clean", fill_o, 1);
  endtask

  // profile 2: size 3; switch to profile 0 (size 10)
  task automatic t_select();
    do_reset();
    prof_sel_i = 2'd2;
    windows(1'b1, 5);
    check("R10 profile 2 size", fill_o, 3);
    check("R3 capped by profile 2", alarm_o, 0);
    prof_sel_i = 2'd0;
    @(negedge clk_i);
    check("R10 fill kept on switch", fill_o, 3);
    window(1'b1);
    check("R10 profile 0 size", fill_o, 4);
  endtask

  initial begin
    prof_size_i[0] = 8'd10;  prof_upper_i[0] = 8'd5;   prof_lower_i[0] = 8'd2; prof_decay_i[0] = 2'd0;
    prof_size_i[1] = 8'd20;  prof_upper_i[1] = 8'd100; prof_lower_i[1] = 8'd0; prof_decay_i[1] = 2'd2;
    prof_size_i[2] = 8'd3;   prof_upper_i[2] = 8'd255; prof_lower_i[2] = 8'd0; prof_decay_i[2] = 2'd0;
    prof_size_i[3] = 8'd50;  prof_upper_i[3] = 8'd255; prof_lower_i[3] = 8'd0; prof_decay_i[3] = 2'd3;
    t_reset();
    t_ignore();
    t_hysteresis();
    t_decay4();
    t_decay8();
    t_select();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule